// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges reset requests from five internal sources into one system reset pulse. The sources are a comparator that watches two analog levels, a watchdog timeout, a flash access violation, a real-time-clock event and a software write. An external active-low reset input also feeds the block. It clears the block's own state and reads back as a cause of its own.

One 8-bit register serves two purposes. A write arms the comparator and real-time-clock sources, and a write can also request a software reset. A read returns the cause flags, and after every reset exactly one flag is set. The block takes the current power state (active, suspend, sleep) and uses it to decide which sources stay live. It also owns the watchdog's enable and its divide-by-12 clock tick. The watchdog enable comes back on after any reset, and its setting is restored when the part leaves a low-power state.

No internal reset drives the external reset line. This block only produces `sys_rst`.

Top module: `rstctl_top`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst` is high. After release, `cause_rd` reads 8'h01 (bit 0 is the external cause), both arms are clear and the watchdog enable is 1.
- R2: An accepted internal request raises `sys_rst` at the next clock edge and holds it for exactly 4 cycles. Any request that arrives while the pulse is active is ignored.
- R3: After any reset `cause_rd` has exactly one bit set. The bit positions are: bit 6 flash, bit 3 watchdog, bit 5 comparator, bit 7 real-time clock, bit 4 software, bit 0 external. Bits 1 and 2 always read 0.
- R4: When several requests arrive in the same cycle, the flag is chosen by this priority: flash, then watchdog, then comparator, then real-time clock, then software.
- R5: A register write sets the comparator arm from bit 5 (1 arms it, 0 disarms it). An armed comparator resets when `cmp_above` is low, which means the non-inverting level is below the inverting one. The input passes through a two-flop synchronizer, so `sys_rst` rises 3 cycles after `cmp_above` falls.
- R6: In suspend (`pwr_state`=2'b01) or sleep (2'b10 or 2'b11), the comparator resets only if `cmp_wake_en` is 1.
- R7: A register write sets the real-time-clock arm from bit 7. An armed `rtc_event` resets the part in every power state.
- R8: A register write with bit 4 set causes a software reset in every power state.
- R9: `flash_fault` always causes a reset, whatever the arms or the power state.
- R10: `wdt_run` is 1 only when the watchdog enable is set, `pwr_state` is active (2'b00) and `sys_rst` is low. A `wdt_expire` is honoured only while `wdt_run` is 1. `wdt_cfg_wr` sets the enable. Low-power states leave the enable unchanged. Every reset sets the enable to 1.
- R11: While `wdt_run` stays high, `wdt_tick` pulses once every 12 cycles. It never pulses while `wdt_run` is low.
- R12: A register write changes no cause flag unless that write itself causes a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External/power-on reset, active low, asynchronous |
| pwr_state | input | 2 | 00 active, 01 suspend, 10/11 sleep |
| cmp_above | input | 1 | Comparator output, high when non-inverting level is above inverting |
| cmp_wake_en | input | 1 | Comparator also enabled as wake source |
| wdt_expire | input | 1 | Watchdog timeout request |
| flash_fault | input | 1 | Flash access violation request |
| rtc_event | input | 1 | Real-time-clock alarm or oscillator-fail event |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data (bit 7 clock arm, bit 5 comparator arm, bit 4 software reset) |
| wdt_cfg_wr | input | 1 | Watchdog enable write strobe |
| wdt_cfg_en | input | 1 | Watchdog enable value |
| cause_rd | output | 8 | One-hot reset cause flags |
| sys_rst | output | 1 | System reset, active high |
| wdt_run | output | 1 | Watchdog effectively enabled |
| wdt_tick | output | 1 | Watchdog clock tick (system clock / 12) |

## Verification
The collision that matters most is between sources in one cycle. Flash, watchdog, clock and software requests can all land together, in every power state, and the cause flag must then follow the fixed priority. The random phase provokes this by raising several source pulses in the same cycle, with random arms and a random watchdog enable. A bench function predicts the single flag, or predicts that no reset occurs. A second collision is a new request during an active pulse: a directed case fires a clock event in the middle of a flash pulse and checks that neither the pulse length nor the flag changes.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

   typedef enum logic [1:0] {
      PWR_ACTIVE  = 2'b00,
      PWR_SUSPEND = 2'b01,
      PWR_SLEEP   = 2'b10,
      PWR_SLEEP2  = 2'b11
   } pwr_e;

   // source indices, in falling priority
   localparam int NSRC      = 5;
   localparam int SRC_FLASH = 0;
   localparam int SRC_WDT   = 1;
   localparam int SRC_CMP   = 2;
   localparam int SRC_RTC   = 3;
   localparam int SRC_SW    = 4;

   // register bit positions
   localparam int BIT_EXT   = 0;
   localparam int BIT_WDT   = 3;
   localparam int BIT_SW    = 4;
   localparam int BIT_CMP   = 5;
   localparam int BIT_FLASH = 6;
   localparam int BIT_RTC   = 7;

   localparam int SRC_BIT [NSRC] = '{BIT_FLASH, BIT_WDT, BIT_CMP, BIT_RTC, BIT_SW};

endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad
      $error("rstctl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rstctl_prio.sv
module rstctl_prio #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   if (N < 1) begin : g_bad
      $error("rstctl_prio: N must be positive");
   end

   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end
endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad
      $error("rstctl_stretch: CYCLES must be positive");
   end

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            left_q <= '0;
      else if (start)        left_q <= CW'(CYCLES);
      else if (left_q != '0) left_q <= left_q - 1'b1;
   end

   assign active = (left_q != '0);
endmodule

// File: rtl/rstctl_div.sv
module rstctl_div #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (DIV < 1) begin : g_bad
      $error("rstctl_div: DIV must be positive");
   end

   if (DIV == 1) begin : g_pass
      assign tick = run;
   end else begin : g_count
      localparam int DW = $clog2(DIV);
      logic [DW-1:0] phase_q;
      logic          wrap;

      assign wrap = (phase_q == DW'(DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    phase_q <= '0;
         else if (!run) phase_q <= '0;
         else if (wrap) phase_q <= '0;
         else           phase_q <= phase_q + 1'b1;
      end

      assign tick = run & wrap;
   end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top #(
   parameter int REG_W        = 8,
   parameter int PULSE_CYCLES = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int WDT_DIV      = 12
) (
   input  logic             clk,
   input  logic             ext_rst_n,
   input  logic [1:0]       pwr_state,
   input  logic             cmp_above,
   input  logic             cmp_wake_en,
   input  logic             wdt_expire,
   input  logic             flash_fault,
   input  logic             rtc_event,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             wdt_cfg_wr,
   input  logic             wdt_cfg_en,
   output logic [REG_W-1:0] cause_rd,
   output logic             sys_rst,
   output logic             wdt_run,
   output logic             wdt_tick
);
   import rstctl_pkg::*;

   localparam logic [REG_W-1:0] USED_WBITS =
      (REG_W'(1) << BIT_CMP) | (REG_W'(1) << BIT_RTC) | (REG_W'(1) << BIT_SW);

   if (REG_W <= BIT_RTC) begin : g_bad_w
      $error("rstctl_top: REG_W too narrow for the cause bits");
   end

   // comparator synchronizer, idles "above" (no reset)
   logic cmp_s;
   rstctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (ext_rst_n),
      .d     (cmp_above),
      .q     (cmp_s)
   );

   logic low_pwr;
   assign low_pwr = (pwr_e'(pwr_state) != PWR_ACTIVE);

   logic cmp_arm_q, rtc_arm_q, wdt_en_q;
   logic pulse_busy;
   logic fire;

   // request vector, priority order
   logic [NSRC-1:0] req, req_ok, grant;

   assign req[SRC_FLASH] = flash_fault;
   assign req[SRC_WDT]   = wdt_expire & wdt_run;
   assign req[SRC_CMP]   = cmp_arm_q & ~cmp_s & (~low_pwr | cmp_wake_en);
   assign req[SRC_RTC]   = rtc_arm_q & rtc_event;
   assign req[SRC_SW]    = reg_wr & reg_wdata[BIT_SW];

   assign req_ok = req & {NSRC{~pulse_busy}};
   assign fire   = |req_ok;

   rstctl_prio #(.N(NSRC)) u_prio (
      .req   (req_ok),
      .grant (grant)
   );

   logic [REG_W-1:0] cause_next, cause_q;

   always_comb begin
      cause_next = '0;
      for (int s = 0; s < NSRC; s++) begin
         if (grant[s]) cause_next[SRC_BIT[s]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) cause_q <= REG_W'(1) << BIT_EXT;
      else if (fire)  cause_q <= cause_next;
   end

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         cmp_arm_q <= 1'b0;
         rtc_arm_q <= 1'b0;
      end else if (reg_wr) begin
         cmp_arm_q <= reg_wdata[BIT_CMP];
         rtc_arm_q <= reg_wdata[BIT_RTC];
      end
   end

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n)      wdt_en_q <= 1'b1;
      else if (fire)       wdt_en_q <= 1'b1;
      else if (wdt_cfg_wr) wdt_en_q <= wdt_cfg_en;
   end

   rstctl_stretch #(.CYCLES(PULSE_CYCLES)) u_stretch (
      .clk    (clk),
      .rst_n  (ext_rst_n),
      .start  (fire),
      .active (pulse_busy)
   );

   assign sys_rst = pulse_busy | ~ext_rst_n;
   assign wdt_run = wdt_en_q & ~low_pwr & ~sys_rst;

   rstctl_div #(.DIV(WDT_DIV)) u_div (
      .clk   (clk),
      .rst_n (ext_rst_n),
      .run   (wdt_run),
      .tick  (wdt_tick)
   );

   assign cause_rd = cause_q;

   logic unused_wdata;
   assign unused_wdata = ^(reg_wdata & ~USED_WBITS);
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
   parameter int REG_W        = 8,
   parameter int PULSE_CYCLES = 4,
   parameter int WDT_DIV      = 12
) (
   input logic             clk,
   input logic             ext_rst_n,
   input logic [1:0]       pwr_state,
   input logic [REG_W-1:0] cause_rd,
   input logic             sys_rst,
   input logic             wdt_run,
   input logic             wdt_tick
);
   localparam int HW = $clog2(PULSE_CYCLES + 2) + 1;
   localparam int GW = $clog2(WDT_DIV + 1) + 1;

   logic [HW-1:0] hi_cnt;
   logic [GW-1:0] gap_cnt;
   logic          tick_seen;

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n)   hi_cnt <= '0;
      else if (sys_rst) hi_cnt <= (hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1;
      else              hi_cnt <= '0;
   end

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         gap_cnt   <= '0;
         tick_seen <= 1'b0;
      end else if (wdt_tick) begin
         gap_cnt   <= '0;
         tick_seen <= 1'b1;
      end else if (gap_cnt != '1) begin
         gap_cnt   <= gap_cnt + 1'b1;
      end
   end

   // R3
   cause_onehot_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $countones(cause_rd) == 1);

   // R2
   pulse_len_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      ($fell(sys_rst) && $past(ext_rst_n)) |-> (hi_cnt == HW'(PULSE_CYCLES)));

   // R10
   wdt_gate_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (pwr_state != 2'b00) |-> !wdt_run);

   // R11
   tick_gap_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (wdt_tick && tick_seen) |-> (gap_cnt >= GW'(WDT_DIV - 1)));

   // R11
   tick_run_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      wdt_tick |-> (wdt_run && $past(wdt_run)));

   // R12
   cause_hold_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      !$rose(sys_rst) |-> $stable(cause_rd));
endmodule

bind rstctl_top rstctl_chk #(
   .REG_W        (REG_W),
   .PULSE_CYCLES (PULSE_CYCLES),
   .WDT_DIV      (WDT_DIV)
) u_chk (
   .clk       (clk),
   .ext_rst_n (ext_rst_n),
   .pwr_state (pwr_state),
   .cause_rd  (cause_rd),
   .sys_rst   (sys_rst),
   .wdt_run   (wdt_run),
   .wdt_tick  (wdt_tick)
);

// File: tb/rstctl_top_test.sv
module rstctl_top_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       ext_rst_n = 1'b0;
   logic [1:0] pwr_state = 2'b00;
   logic       cmp_above = 1'b1;
   logic       cmp_wake_en = 1'b0;
   logic       wdt_expire = 1'b0;
   logic       flash_fault = 1'b0;
   logic       rtc_event = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic       wdt_cfg_wr = 1'b0;
   logic       wdt_cfg_en = 1'b0;
   logic [7:0] cause_rd;
   logic       sys_rst, wdt_run, wdt_tick;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   logic [7:0] m_cause;
   logic       m_cmp_arm, m_rtc_arm, m_wdt_en;

   always #(CLK_PERIOD/2) clk = ~clk;

   rstctl_top uut (
      .clk(clk), .ext_rst_n(ext_rst_n), .pwr_state(pwr_state),
      .cmp_above(cmp_above), .cmp_wake_en(cmp_wake_en),
      .wdt_expire(wdt_expire), .flash_fault(flash_fault), .rtc_event(rtc_event),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .wdt_cfg_wr(wdt_cfg_wr), .wdt_cfg_en(wdt_cfg_en),
      .cause_rd(cause_rd), .sys_rst(sys_rst), .wdt_run(wdt_run), .wdt_tick(wdt_tick)
   );

   task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [7:0] predict(bit f, bit w, bit r, bit s, logic [1:0] p);
      if (f)                                   return 8'h40;
      if (w && m_wdt_en && p == 2'b00)         return 8'h08;
      if (r && m_rtc_arm)                      return 8'h80;
      if (s)                                   return 8'h10;
      return 8'h00;
   endfunction

   function automatic logic [7:0] arm_word(bit sw);
      return {m_rtc_arm, 1'b0, m_cmp_arm, sw, 4'h0};
   endfunction

   // verify a pulse that is high at the current negedge
   task automatic pulse_len(string rq);
      int hi = 1;
      repeat (5) begin
         @(negedge clk);
         if (sys_rst) hi++;
      end
      chk(rq, hi, 4);
   endtask

   task automatic fire(bit f, bit w, bit r, bit s, string rq);
      logic [7:0] e;
      e = predict(f, w, r, s, pwr_state);
      @(negedge clk);
      flash_fault = f; wdt_expire = w; rtc_event = r;
      if (s) begin reg_wr = 1'b1; reg_wdata = arm_word(1'b1); end
      @(negedge clk);
      flash_fault = 0; wdt_expire = 0; rtc_event = 0; reg_wr = 0; reg_wdata = 8'h00;
      if (e != 8'h00) begin
         chk({rq, " sys_rst rise"}, sys_rst, 1);
         chk({rq, " cause"}, cause_rd, e);
         m_cause = e;
         m_wdt_en = 1'b1;
         pulse_len({rq, " R2 length"});
      end else begin
         chk({rq, " no reset"}, sys_rst, 0);
         chk({rq, " cause kept"}, cause_rd, m_cause);
      end
   endtask

   task automatic write_arms(bit c, bit r);
      m_cmp_arm = c; m_rtc_arm = r;
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = arm_word(1'b0) | 8'h4F;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 8'h00;
      chk("R12 write keeps cause", cause_rd, m_cause);
   endtask

   task automatic set_wdt(bit en);
      @(negedge clk);
      wdt_cfg_wr = 1'b1; wdt_cfg_en = en;
      @(negedge clk);
      wdt_cfg_wr = 1'b0;
      m_wdt_en = en;
   endtask

   task automatic cmp_case(logic [1:0] p, bit wake, bit expect_rst, string rq);
      int lat = 0;
      pwr_state = p; cmp_wake_en = wake;
      @(negedge clk);
      cmp_above = 1'b0;
      while (!sys_rst && lat < 8) begin
         @(negedge clk);
         lat++;
      end
      cmp_above = 1'b1;
      if (expect_rst) begin
         chk({rq, " R5 latency"}, lat, 3);
         chk({rq, " cause"}, cause_rd, 8'h20);
         m_cause = 8'h20; m_wdt_en = 1'b1;
         repeat (6) @(negedge clk);
         chk({rq, " pulse ended"}, sys_rst, 0);
      end else begin
         chk({rq, " no reset"}, sys_rst, 0);
         chk({rq, " cause kept"}, cause_rd, m_cause);
         repeat (3) @(negedge clk);
      end
      pwr_state = 2'b00; cmp_wake_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R2 watchdog expired actual=hang expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int ticks;
      void'($urandom(32'h5EED_1234));
      m_cause = 8'h01; m_cmp_arm = 0; m_rtc_arm = 0; m_wdt_en = 1;

      // R1 external reset
      repeat (3) @(negedge clk);
      chk("R1 sys_rst during ext reset", sys_rst, 1);
      chk("R1 cause during ext reset", cause_rd, 8'h01);
      ext_rst_n = 1'b1;
      @(negedge clk);
      chk("R1 sys_rst after release", sys_rst, 0);
      chk("R1 wdt enabled", wdt_run, 1);
      fire(0, 0, 1, 0, "R1 rtc disarmed after reset");

      // R9, R8, R7 single sources
      fire(1, 0, 0, 0, "R9 flash");
      pwr_state = 2'b10;
      fire(0, 0, 0, 1, "R8 software in sleep");
      fire(1, 0, 0, 0, "R9 flash in sleep");
      write_arms(0, 1);
      fire(0, 0, 1, 0, "R7 rtc in sleep");
      pwr_state = 2'b01;
      fire(0, 0, 1, 0, "R7 rtc in suspend");
      pwr_state = 2'b00;

      // R4 priority
      fire(1, 1, 1, 1, "R4 all four");
      fire(0, 1, 1, 1, "R4 wdt over rtc");
      fire(0, 0, 1, 1, "R4 rtc over sw");

      // R2 request during pulse ignored
      @(negedge clk); flash_fault = 1;
      @(negedge clk); flash_fault = 0;
      @(negedge clk); rtc_event = 1;
      @(negedge clk); rtc_event = 0;
      repeat (3) @(negedge clk);
      chk("R2 pulse over", sys_rst, 0);
      chk("R2 late request ignored", cause_rd, 8'h40);
      m_cause = 8'h40;

      // R10 watchdog gating and restore
      set_wdt(0);
      chk("R10 disabled", wdt_run, 0);
      fire(0, 1, 0, 0, "R10 expire while disabled");
      pwr_state = 2'b01; @(negedge clk); pwr_state = 2'b00; @(negedge clk);
      chk("R10 disabled kept", wdt_run, 0);
      set_wdt(1);
      pwr_state = 2'b10; @(negedge clk);
      chk("R10 forced off in sleep", wdt_run, 0);
      fire(0, 1, 0, 0, "R10 expire in sleep");
      pwr_state = 2'b00; @(negedge clk);
      chk("R10 restored", wdt_run, 1);
      fire(0, 1, 0, 0, "R10 expire active");
      set_wdt(0);
      fire(0, 0, 0, 1, "R10 sw reset re-enables");
      chk("R10 enabled after reset", wdt_run, 1);

      // R11 divider
      repeat (2) @(negedge clk);
      ticks = 0;
      repeat (120) begin @(negedge clk); if (wdt_tick) ticks++; end
      chk("R11 ticks in 120 cycles", ticks, 10);
      pwr_state = 2'b01;
      ticks = 0;
      repeat (48) begin @(negedge clk); if (wdt_tick) ticks++; end
      chk("R11 no ticks in suspend", ticks, 0);
      pwr_state = 2'b00;

      // R5, R6 comparator
      write_arms(1, 1);
      cmp_case(2'b00, 0, 1, "R5 active");
      cmp_case(2'b10, 0, 0, "R6 sleep no wake");
      cmp_case(2'b01, 1, 1, "R6 suspend with wake");
      write_arms(0, 1);
      cmp_case(2'b00, 0, 0, "R5 disarmed");

      // random collisions
      for (int i = 0; i < 300; i++) begin
         logic [31:0] r;
         r = $urandom;
         pwr_state = r[1:0];
         if (r[4:2] == 3'd0) set_wdt(r[5]);
         if (r[8:6] == 3'd0) write_arms(0, r[9]);
         fire(r[12:10] < 3'd2, r[15:13] < 3'd3, r[18:16] < 3'd3, r[21:19] < 3'd2,
              "R4 random mix");
         chk("R3 one flag", $countones(cause_rd), 1);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule